// File: doc/BRIEF.md
# SPI Slave Transceiver with Phase-Dependent Framing

This block is the target side of a four-wire synchronous serial link. The serial clock, data-in and select lines arrive from an external master. Each goes through a two-flop synchronizer into a much faster system clock, and clock edges are found in that domain. The system clock must run at least four times faster than the serial clock. Each frame moves eight bits in both directions at once, most significant bit first. The block takes a parallel byte to send, returns the byte it received, and raises a one-cycle strobe when a full byte has arrived. The data-out line is enabled only while the block is enabled and selected.

Three configuration bits are written through a one-cycle write port: enable, clock polarity and clock phase. The polarity and phase bits are locked while the block is enabled. In phase-0 mode the falling edge of select starts a byte, and each byte needs its own select assertion. In phase-1 mode select may stay low across any number of bytes.

Top module: `spi_target_port`

## Requirements
- R1: After reset, sdo_oe is 0, rx_valid is 0 and rx_byte is 0.
- R2: sdo_oe is 1 only while the block is enabled and sel_n_in (after synchronization) is 0, and is 0 otherwise.
- R3: cfg_pol gives the idle level of sclk_in. The leading edge is rising when cfg_pol=0 and falling when cfg_pol=1. The trailing edge is the opposite one.
- R4: With cfg_pha=0, tx_byte is loaded when select falls, so its bit 7 is on sdo before any clock edge. Bits are captured from sdi_in on leading edges, and sdo advances on trailing edges.
- R5: With cfg_pha=1, a leading edge drives the next bit on sdo and a trailing edge captures sdi_in. The first leading edge of each byte loads tx_byte, so select may stay low across several bytes and each byte carries a fresh tx_byte.
- R6: A frame is 8 bits, bit 7 first and bit 0 last, and both directions move in the same 8 clock cycles.
- R7: With cfg_pha=0, after the 8th capture no further bit is captured and no strobe is raised until select goes high and low again.
- R8: If select rises before 8 captures, the partial byte is dropped and no strobe is raised. The next frame starts from bit 7.
- R9: After the 8th capture, rx_byte takes the received byte and rx_valid is high for exactly one cycle. rx_byte then holds its value until the next complete byte.
- R10: A write with cfg_we=1 always updates enable. It updates polarity and phase only if the block was disabled before that write. Writes to polarity or phase made while enabled are ignored.
- R11: While disabled, the block captures nothing, raises no strobe and does not drive sdo.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value to write |
| cfg_pol | input | 1 | Clock polarity value to write |
| cfg_pha | input | 1 | Clock phase value to write |
| tx_byte | input | WIDTH | Byte to send in the next frame |
| rx_byte | output | WIDTH | Last complete received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |
| sclk_in | input | 1 | Serial clock from the master |
| sdi_in | input | 1 | Serial data from the master |
| sel_n_in | input | 1 | Active-low select from the master |
| sdo | output | 1 | Serial data to the master |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
A vector table runs all four polarity and phase pairs with bit patterns that are alternating, asymmetric, all ones and all zeros. A swapped bit order, a wrong capture edge or a stuck lane shows up as a wrong byte in one direction. Directed cases hold select low across two bytes in each phase mode. This separates the phase-1 reload from the phase-0 lockout. Other directed cases cut a frame short and write the mode while enabled, then check whether a later frame still uses the old format. A frame sent while the block is disabled must leave the strobe count and the output enable unchanged.

// File: rtl/spi_target_port.sv
module spi_target_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic             cfg_pol,
  input  logic             cfg_pha,
  input  logic [WIDTH-1:0] tx_byte,
  output logic [WIDTH-1:0] rx_byte,
  output logic             rx_valid,
  input  logic             sclk_in,
  input  logic             sdi_in,
  input  logic             sel_n_in,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic en_q, pol_q, pha_q;
  logic [2:0] sclk_r, seln_r;
  logic [1:0] sdi_r;
  logic [WIDTH-1:0] txs, rxs;
  logic [CW-1:0] cnt;
  logic done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      pol_q <= 1'b0;
      pha_q <= 1'b0;
    end else if (cfg_we) begin
      en_q <= cfg_en;
      if (!en_q) begin
        pol_q <= cfg_pol;
        pha_q <= cfg_pha;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r <= '0;
      seln_r <= '1;
      sdi_r  <= '0;
    end else begin
      sclk_r <= {sclk_r[1:0], sclk_in};
      seln_r <= {seln_r[1:0], sel_n_in};
      sdi_r  <= {sdi_r[0], sdi_in};
    end
  end

  wire rise     = sclk_r[1] & ~sclk_r[2];
  wire fall     = ~sclk_r[1] & sclk_r[2];
  wire lead     = pol_q ? fall : rise;
  wire trail    = pol_q ? rise : fall;
  wire sel      = en_q & ~seln_r[1];
  wire sel_fall = sel & seln_r[2];
  wire cap      = sel & ~done & (pha_q ? trail : lead);
  wire shft     = sel & (pha_q ? lead : trail);
  wire [WIDTH-1:0] rx_next = {rxs[WIDTH-2:0], sdi_r[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txs      <= '0;
      rxs      <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!sel) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (sel_fall) begin
        cnt  <= '0;
        done <= 1'b0;
        txs  <= tx_byte;
      end else begin
        if (shft)
          txs <= (pha_q && cnt == '0) ? tx_byte : {txs[WIDTH-2:0], 1'b0};
        if (cap) begin
          rxs <= rx_next;
          if (cnt == LAST) begin
            rx_byte  <= rx_next;
            rx_valid <= 1'b1;
            cnt      <= '0;
            done     <= ~pha_q;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  assign sdo    = txs[WIDTH-1];
  assign sdo_oe = sel;

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> ($stable(pol_q) && $stable(pha_q)));

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seln_r[1]) |=> (cnt == '0));

  // R7
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> !rx_valid);

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && $past(!en_q)) |-> (!rx_valid && !sdo_oe));
endmodule

// File: tb/spi_target_port_tb.sv
module spi_target_port_tb;
  localparam int CLK_P = 10;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0, cfg_pol = 0, cfg_pha = 0;
  logic [7:0] tx_byte = 0;
  logic [7:0] rx_byte;
  logic rx_valid;
  logic sclk = 0, sdi = 0, sel_n = 1;
  logic sdo, sdo_oe;

  int checks = 0, fails = 0, vcnt = 0;
  logic [7:0] vlast = 0;
  bit finished = 0;

  spi_target_port #(.WIDTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
    .cfg_pol(cfg_pol), .cfg_pha(cfg_pha), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .sclk_in(sclk),
    .sdi_in(sdi), .sel_n_in(sel_n), .sdo(sdo), .sdo_oe(sdo_oe));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (rx_valid) begin vcnt++; vlast = rx_byte; end

  // {pol, pha, master byte, slave tx byte}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C}, {1'b1, 1'b0, 8'h81, 8'h7E},
    {1'b0, 1'b1, 8'h5A, 8'hC3}, {1'b1, 1'b1, 8'h01, 8'h80},
    {1'b0, 1'b0, 8'hFF, 8'h00}, {1'b1, 1'b1, 8'h00, 8'hFF},
    {1'b0, 1'b1, 8'h96, 8'h69}, {1'b1, 1'b0, 8'h12, 8'hED}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic en, input logic pol, input logic pha);
    cfg_we = 1; cfg_en = en; cfg_pol = pol; cfg_pha = pha;
    clks(1);
    cfg_we = 0;
    clks(2);
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    cfg_write(0, pol, pha);
    sclk = pol;
    clks(4);
    cfg_write(1, pol, pha);
  endtask

  task automatic sel_lo();
    sel_n = 0; clks(H);
  endtask

  task automatic sel_hi();
    clks(H); sel_n = 1; clks(H);
  endtask

  task automatic frame(input logic pol, input logic pha, input logic [7:0] mo,
                       input int nbits, output logic [7:0] mi);
    mi = 0;
    for (int i = 0; i < nbits; i++) begin
      if (!pha) begin
        sdi = mo[7-i]; clks(H);
        mi[7-i] = sdo; sclk = ~pol; clks(H);
        sclk = pol;
      end else begin
        sclk = ~pol; sdi = mo[7-i]; clks(H);
        mi[7-i] = sdo; sclk = pol; clks(H);
      end
    end
    clks(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi, mi2;
    int v0;
    clks(3);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rx_byte", rx_byte, 0);
    rst_n = 1;
    clks(3);

    // table walk: R3 polarity, R4/R5 phase, R6 frame, R9 strobe
    for (int i = 0; i < 8; i++) begin
      logic p, h;
      logic [7:0] mo, so;
      {p, h, mo, so} = VEC[i];
      set_mode(p, h);
      tx_byte = so;
      v0 = vcnt;
      sel_lo();
      if (!h) chk("R4 msb before edge", sdo, so[7]);
      frame(p, h, mo, 8, mi);
      sel_hi();
      chk("R6/R3 slave rx", vlast, mo);
      chk("R6/R3 master rx", mi, so);
      chk("R9 one strobe", vcnt - v0, 1);
      clks(20);
      chk("R9 rx_byte holds", rx_byte, mo);
    end

    // R2 output enable
    set_mode(0, 0);
    chk("R2 oe deselected", sdo_oe, 0);
    sel_n = 0; clks(4);
    chk("R2 oe selected", sdo_oe, 1);
    sel_n = 1; clks(4);
    chk("R2 oe released", sdo_oe, 0);

    // R5 phase 1, select held across two bytes
    set_mode(1, 1);
    v0 = vcnt;
    tx_byte = 8'hC5;
    sel_lo();
    frame(1, 1, 8'h3A, 8, mi);
    chk("R5 byte1 rx", vlast, 8'h3A);
    tx_byte = 8'h4E;
    frame(1, 1, 8'hB7, 8, mi2);
    sel_hi();
    chk("R5 byte1 tx", mi, 8'hC5);
    chk("R5 byte2 tx", mi2, 8'h4E);
    chk("R5 byte2 rx", vlast, 8'hB7);
    chk("R5 strobes", vcnt - v0, 2);

    // R7 phase 0, no select toggle between bytes
    set_mode(0, 0);
    v0 = vcnt;
    tx_byte = 8'h99;
    sel_lo();
    frame(0, 0, 8'h6D, 8, mi);
    frame(0, 0, 8'hF0, 8, mi2);
    sel_hi();
    chk("R7 single strobe", vcnt - v0, 1);
    chk("R7 first byte kept", rx_byte, 8'h6D);

    // R8 partial frame dropped
    v0 = vcnt;
    tx_byte = 8'hB4;
    sel_lo();
    frame(0, 0, 8'hE1, 5, mi);
    sel_hi();
    chk("R8 no strobe", vcnt - v0, 0);
    chk("R8 rx_byte unchanged", rx_byte, 8'h6D);
    sel_lo();
    frame(0, 0, 8'h2C, 8, mi);
    sel_hi();
    chk("R8 next frame rx", vlast, 8'h2C);
    chk("R8 next frame tx", mi, 8'hB4);

    // R10 mode write while enabled ignored
    cfg_write(1, 1, 1);
    v0 = vcnt;
    tx_byte = 8'h5C;
    sel_lo();
    frame(0, 0, 8'hA3, 8, mi);
    sel_hi();
    chk("R10 old mode rx", vlast, 8'hA3);
    chk("R10 old mode tx", mi, 8'h5C);
    chk("R10 strobe", vcnt - v0, 1);

    // R11 disabled
    cfg_write(0, 0, 0);
    v0 = vcnt;
    sel_lo();
    chk("R11 no drive", sdo_oe, 0);
    frame(0, 0, 8'h77, 8, mi);
    sel_hi();
    chk("R11 no strobe", vcnt - v0, 0);
    chk("R11 rx_byte unchanged", rx_byte, 8'hA3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule